// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block gates a group of clock outputs that all derive from one source clock. An active-low, asynchronous stop request is brought into the source clock domain through a short synchronizer chain. A per-output enable flop, loaded on the falling edge, then opens or closes each output. The gate is an AND on the true side and an OR on the complement side, so an output can only change state while the source clock is low. Outputs park low and restart only on a whole high phase. No shortened pulse can reach a load.

A parameter selects the output style. The differential style drives a complement line that is the exact inverse of the true line, so a parked pair rests with true low and complement high. The single-ended style holds the complement lines at zero. The stage count of the synchronizer sets the stop and start latency. A processor-style group uses two stages, which gives a two-cycle latency, well under four cycles. A peripheral-style group uses one stage, which gives a one-cycle latency. A per-output mask, normally driven by a control register in the same clock domain, keeps individual outputs parked even while the group runs. An ungated copy of the source clock is always present for the free-running member of the group.

Top module: `clock_stop_gate`

## Requirements
- R1: If `stop_n` is sampled low at rising edge k of `clk_in`, the high pulses at edges k to k+SYNC_STAGES-1 still appear. Every enabled `gclk_t` bit stays low from edge k+SYNC_STAGES for as long as `stop_n` stays low.
- R2: If `stop_n` is sampled high at rising edge k, after being low, the first high pulse of each enabled output appears at edge k+SYNC_STAGES. That pulse lasts the whole high phase of `clk_in`.
- R3: Every `gclk_t` bit is low whenever `clk_in` is low. It holds one level through each entire high phase of `clk_in`, so no partial pulse appears.
- R4: With KIND = GATE_DIFF, each `gclk_c` bit is the inverse of its `gclk_t` bit at all times, so it is high while stopped. With KIND = GATE_SINGLE, `gclk_c` is all zeros.
- R5: Bit i of `en_mask` is 1 to enable output i and 0 to park it. The value present at the falling edge before rising edge e sets whether output i may pulse at edge e. A parked output stays low while the group runs.
- R6: `free_clk` follows `clk_in` at all times, regardless of `stop_n`, `en_mask` and `rst`.
- R7: `rst` is synchronous and active high. The first falling edge that sees it parks every gated output. After `rst` is last sampled high at edge r, no gated output pulses before edge r+SYNC_STAGES+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Source clock that is gated and that clocks the block |
| rst | input | 1 | Synchronous active-high reset, parks all gated outputs |
| stop_n | input | 1 | Asynchronous active-low group stop request |
| en_mask | input | NUM_OUT | Per-output enable, 1 = may run |
| gclk_t | output | NUM_OUT | Gated true clocks, park low |
| gclk_c | output | NUM_OUT | Gated complement clocks (differential style), park high |
| free_clk | output | 1 | Ungated copy of the source clock |

## Verification
Two instances share one stimulus stream: a two-stage differential group and a one-stage single-ended group. Because they differ only in latency and output style, a latency off by one shows up as a disagreement with the expected history.

Directed cases cover the following:
- a single-cycle stop request, which must remove exactly one pulse after the sync delay;
- a longer stop, which separates the stop edge from the restart edge;
- an all-zero mask, which shows parking while the group runs;
- reset in the middle of a run.

Random runs of `stop_n`, mask and occasional reset follow, with sampling in each cycle:
- early and late in the high phase, which tells a full pulse from a clipped one;
- in the low phase, which tells proper parking from a leak on the true or complement line.

// File: rtl/csg_pkg.sv
package csg_pkg;

  // Output style of a gated group
  typedef enum logic [0:0] {
    GATE_SINGLE = 1'b0,
    GATE_DIFF   = 1'b1
  } gate_kind_e;

  localparam int unsigned CSG_MIN_SYNC = 1;

endpackage

// File: rtl/csg_stop_sync.sv
module csg_stop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_in,
  input  logic rst,
  input  logic stop_n,
  output logic run_sync
);
  // Rising-edge synchronizer chain; reset state means "stopped"
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_in) begin
        if (rst) chain_q <= 1'b0;
        else     chain_q <= stop_n;
      end
    end else begin : g_many
      always_ff @(posedge clk_in) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], stop_n};
      end
    end
  endgenerate

  assign run_sync = chain_q[STAGES-1];
endmodule

// File: rtl/csg_enable_reg.sv
module csg_enable_reg #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic             run_sync,
  input  logic [WIDTH-1:0] en_mask,
  output logic [WIDTH-1:0] en_q
);
  // Loaded while the source clock is low, so the gate never opens or
  // closes in the middle of a high phase.
  always_ff @(negedge clk_in) begin
    if (rst) en_q <= '0;
    else     en_q <= en_mask & {WIDTH{run_sync}};
  end
endmodule

// File: rtl/csg_gate_cell.sv
module csg_gate_cell
  import csg_pkg::*;
#(
  parameter gate_kind_e KIND = GATE_DIFF
) (
  input  logic clk_in,
  input  logic en,
  output logic out_t,
  output logic out_c
);
  always_comb out_t = clk_in & en;

  generate
    if (KIND == GATE_DIFF) begin : g_diff
      always_comb out_c = (~clk_in) | (~en);
    end else begin : g_single
      always_comb out_c = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/clock_stop_gate.sv
module clock_stop_gate
  import csg_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter gate_kind_e  KIND        = GATE_DIFF
) (
  input  logic               clk_in,
  input  logic               rst,
  input  logic               stop_n,
  input  logic [NUM_OUT-1:0] en_mask,
  output logic [NUM_OUT-1:0] gclk_t,
  output logic [NUM_OUT-1:0] gclk_c,
  output logic               free_clk
);
  localparam int unsigned STAGES_EFF =
    (SYNC_STAGES < CSG_MIN_SYNC) ? CSG_MIN_SYNC : SYNC_STAGES;

  logic               run_sync;
  logic [NUM_OUT-1:0] en_q;

  csg_stop_sync #(.STAGES(STAGES_EFF)) u_sync (
    .clk_in   (clk_in),
    .rst      (rst),
    .stop_n   (stop_n),
    .run_sync (run_sync)
  );

  csg_enable_reg #(.WIDTH(NUM_OUT)) u_en (
    .clk_in   (clk_in),
    .rst      (rst),
    .run_sync (run_sync),
    .en_mask  (en_mask),
    .en_q     (en_q)
  );

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      csg_gate_cell #(.KIND(KIND)) u_cell (
        .clk_in (clk_in),
        .en     (en_q[i]),
        .out_t  (gclk_t[i]),
        .out_c  (gclk_c[i])
      );
    end
  endgenerate

  assign free_clk = clk_in;
endmodule

// File: rtl/clock_stop_gate_chk.sv
module clock_stop_gate_chk
  import csg_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter gate_kind_e  KIND        = GATE_DIFF
) (
  input logic               clk_in,
  input logic               rst,
  input logic               stop_n,
  input logic [NUM_OUT-1:0] en_mask,
  input logic [NUM_OUT-1:0] gclk_t,
  input logic [NUM_OUT-1:0] gclk_c,
  input logic               free_clk
);
  localparam int unsigned CW = $clog2(SYNC_STAGES + 2) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(SYNC_STAGES + 1);

  // Consecutive rising edges that sampled a stop request
  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk_in) begin
    if (rst || stop_n)        low_cnt <= '0;
    else if (low_cnt < LIMIT) low_cnt <= low_cnt + 1'b1;
  end

  // R3
  low_phase_park_chk: assert property (@(posedge clk_in) disable iff (rst)
    gclk_t == '0);

  // R1
  stop_latency_chk: assert property (@(negedge clk_in) disable iff (rst)
    (low_cnt >= LIMIT) |-> (gclk_t == '0));

  // R5
  mask_park_chk: assert property (@(negedge clk_in) disable iff (rst)
    (gclk_t & ~$past(en_mask)) == '0);

  // R6
  free_run_chk: assert property (@(negedge clk_in) disable iff (rst)
    free_clk == 1'b1);

  generate
    if (KIND == GATE_DIFF) begin : g_diff
      // R4
      comp_inverse_chk: assert property (@(negedge clk_in) disable iff (rst)
        gclk_c == ~gclk_t);
    end else begin : g_single
      // R4
      comp_zero_chk: assert property (@(negedge clk_in) disable iff (rst)
        gclk_c == '0);
    end
  endgenerate
endmodule

bind clock_stop_gate clock_stop_gate_chk #(
  .NUM_OUT(NUM_OUT), .SYNC_STAGES(SYNC_STAGES), .KIND(KIND)
) u_chk (
  .clk_in(clk_in), .rst(rst), .stop_n(stop_n), .en_mask(en_mask),
  .gclk_t(gclk_t), .gclk_c(gclk_c), .free_clk(free_clk)
);

// File: tb/clock_stop_gate_bench.sv
module clock_stop_gate_bench;
  import csg_pkg::*;

  localparam int NCYC  = 3000;
  localparam int N_A   = 3;   // differential group, two sync stages
  localparam int S_A   = 2;
  localparam int N_B   = 7;   // single-ended group, one sync stage
  localparam int S_B   = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;      // 50 MHz

  logic           rst    = 1'b1;
  logic           stop_n = 1'b1;
  logic [7:0]     mask   = 8'hFF;
  logic [N_A-1:0] a_t, a_c;
  logic [N_B-1:0] b_t, b_c;
  logic           a_free, b_free;

  clock_stop_gate #(.NUM_OUT(N_A), .SYNC_STAGES(S_A), .KIND(GATE_DIFF)) u_clock_stop_gate (
    .clk_in(clk), .rst(rst), .stop_n(stop_n), .en_mask(mask[N_A-1:0]),
    .gclk_t(a_t), .gclk_c(a_c), .free_clk(a_free));

  clock_stop_gate #(.NUM_OUT(N_B), .SYNC_STAGES(S_B), .KIND(GATE_SINGLE)) u_clock_stop_gate_pci (
    .clk_in(clk), .rst(rst), .stop_n(stop_n), .en_mask(mask[N_B-1:0]),
    .gclk_t(b_t), .gclk_c(b_c), .free_clk(b_free));

  // Stimulus history: entry c is driven just after rising edge c
  logic       rst_h  [NCYC];
  logic       stop_h [NCYC];
  logic [7:0] mask_h [NCYC];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected pulse vector at rising edge e for a group with s sync stages
  function automatic logic [7:0] exp_pulse(int e, int s);
    if (e - 1 - s < 0) return 8'h00;
    for (int j = e - 1 - s; j <= e - 1; j++)
      if (rst_h[j]) return 8'h00;
    return stop_h[e-1-s] ? mask_h[e-1] : 8'h00;
  endfunction

  function automatic string exp_tag(int e, int s);
    if (e - 1 - s < 0) return "R7";
    for (int j = e - 1 - s; j <= e - 1; j++)
      if (rst_h[j]) return "R7";
    if (mask_h[e-1] == 8'h00) return "R5";
    return stop_h[e-1-s] ? "R2" : "R1";
  endfunction

  initial begin
    void'($urandom(32'd5150));
    // directed prefix
    for (int c = 0; c < NCYC; c++) begin
      rst_h[c] = (c < 4);
      stop_h[c] = 1'b1;
      mask_h[c] = 8'hFF;
    end
    stop_h[20] = 1'b0;                          // one-cycle stop (R1, R2)
    for (int c = 30; c < 36; c++) stop_h[c] = 1'b0; // longer stop
    for (int c = 42; c < 46; c++) mask_h[c] = 8'h00; // all parked (R5)
    mask_h[50] = 8'h05;
    for (int c = 56; c < 58; c++) rst_h[c] = 1'b1;  // mid-run reset (R7)
    // random tail with runs
    for (int c = 70; c < NCYC; c++) begin
      stop_h[c] = (($urandom % 8) == 0) ? ~stop_h[c-1] : stop_h[c-1];
      mask_h[c] = (($urandom % 16) == 0) ? 8'($urandom) : mask_h[c-1];
      rst_h[c]  = (($urandom % 200) == 0);
    end

    for (int c = 0; c < NCYC; c++) begin
      logic [7:0] ea, eb;
      @(posedge clk);
      #3;
      rst = rst_h[c]; stop_n = stop_h[c]; mask = mask_h[c];
      if (c >= 2) begin
        ea = exp_pulse(c, S_A) & 8'(2**N_A - 1);
        eb = exp_pulse(c, S_B) & 8'(2**N_B - 1);
        #2;  // early high phase
        chk(a_t == ea[N_A-1:0], exp_tag(c, S_A), "diff true early", 8'(a_t), ea);
        chk(b_t == eb[N_B-1:0], exp_tag(c, S_B), "single true early", 8'(b_t), eb);
        chk(a_c == ~ea[N_A-1:0], "R4", "diff comp high phase", 8'(a_c), 8'(~ea[N_A-1:0]));
        chk(b_c == '0, "R4", "single comp high phase", 8'(b_c), 8'h00);
        chk(a_free && b_free, "R6", "free high", {6'd0, a_free, b_free}, 8'h03);
        #4;  // late high phase: full-width pulse
        chk(a_t == ea[N_A-1:0], "R3", "diff true late", 8'(a_t), ea);
        chk(b_t == eb[N_B-1:0], "R3", "single true late", 8'(b_t), eb);
        #6;  // low phase: parked
        chk(a_t == '0 && b_t == '0, "R3", "true low phase", {a_t, 5'd0}, 8'h00);
        chk(a_c == '1, "R4", "diff comp low phase", 8'(a_c), 8'(2**N_A - 1));
        chk(!a_free && !b_free, "R6", "free low", {6'd0, a_free, b_free}, 8'h00);
      end else begin
        #7;
        chk(a_t == '0 && b_t == '0, "R7", "reset park", {a_t, 5'd0}, 8'h00);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(NCYC * 20 * 3);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule